// File: doc/BRIEF.md
# Pointer Addressing Mode Unit

This unit forms the effective data address for a load or store. It supports five modes. Direct mode passes a full 16-bit address through. Plain indirect mode uses one of three pointer registers as the address. Displacement mode adds a small unsigned offset to a pointer. The two auto-update modes are pre-decrement and post-increment.

The unit holds the three 16-bit pointers. Each pointer is the pair of byte registers that the wider register file maps onto it. The pointers are named X, Y and Z. In each pair, the lower-numbered byte register is the low byte. The address is combinational from the current pointer state. When a request is valid, any auto-update is written back on the clock edge that consumes the address. Load ports let the surrounding datapath write a pointer. A load takes priority over an auto-update of the same pointer. Because the address is a full 16 bits, every mode reaches the register, I/O and SRAM regions of the data space. Instruction decoding and the memory access itself are outside this unit.

Top module: `ptr_addr_unit`

## Requirements
- R1: While `rst_n` is low, all three pointers read zero.
- R2: Mode code 0 (direct) gives `eff_addr` = `dir_addr` over the full 16-bit range. No pointer changes.
- R3: Mode code 1 (indirect) gives `eff_addr` = the selected pointer. The select codes are X=0, Y=1 and Z=2. No pointer changes.
- R4: Mode code 2 (displacement) with Y or Z selected gives `eff_addr` = pointer + `disp`. The offset `disp` is unsigned, from 0 to 63, and the sum wraps modulo 2^16. The pointer does not change.
- R5: Mode code 2 with X selected raises `illegal` and drives `eff_addr` to 0. All pointers stay unchanged.
- R6: Mode code 3 (pre-decrement) gives `eff_addr` = pointer − 1. After a valid request, the pointer holds that value.
- R7: Mode code 4 (post-increment) gives `eff_addr` = the current pointer value. After a valid request, the pointer holds pointer + 1.
- R8: The auto-updates wrap modulo 2^16. Pre-decrement of 0x0000 gives 0xFFFF, and post-increment of 0xFFFF gives 0x0000.
- R9: A load of a pointer (`ptr_ld_en[i]` with the data taken from `ptr_ld_data[16*i +: 16]`) overrides an auto-update of the same pointer in that cycle. Loads of other pointers apply alongside the auto-update.
- R10: With `req_valid` low, no auto-update occurs.
- R11: Select code 3 with any pointer mode raises `illegal`. So do mode codes 5 to 7. In either case `eff_addr` is 0 and no pointer changes.
- R12: An auto-update changes only the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address is consumed this cycle; auto-update commits at the edge |
| mode | input | 3 | Addressing mode code (0 to 4) |
| ptr_sel | input | 2 | Pointer select: X=0, Y=1, Z=2 |
| disp | input | 6 | Unsigned displacement |
| dir_addr | input | 16 | Direct address |
| ptr_ld_en | input | 3 | Per-pointer load enable (bit 0 = X) |
| ptr_ld_data | input | 48 | Load values, 16 bits per pointer |
| eff_addr | output | 16 | Effective address |
| illegal | output | 1 | Mode/select combination not allowed |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |
| ptr_z | output | 16 | Pointer Z |

## Verification
The assertions are checked on every cycle. They cover the following:
- the reset value of the pointers;
- the step of the post-increment and pre-decrement writeback;
- the stability of the pointers on illegal or idle cycles;
- the priority of a load over an auto-update;
- the pass-through of the direct address.

Some behaviours are shown only by the bench scenarios:
- the exact displacement sums, including the wrap past 0xFFFF;
- the boundary wraps of both auto-update modes;
- the isolation of the unselected pointers;
- a simultaneous load of one pointer during an update of another.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
    localparam int ADDR_W  = 16;
    localparam int DISP_W  = 6;
    localparam int PTR_NUM = 3;
    localparam int SEL_W   = 2;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } am_mode_e;

    typedef enum logic [SEL_W-1:0] {
        PS_X   = 2'd0,
        PS_Y   = 2'd1,
        PS_Z   = 2'd2,
        PS_RSV = 2'd3
    } ptr_sel_e;
endpackage

// File: rtl/ptr_ea_gen.sv
module ptr_ea_gen
    import ptr_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DISP_W,
    parameter int NP = PTR_NUM
) (
    input  logic [NP-1:0][AW-1:0] ptrs,
    input  logic                  req_valid,
    input  logic [MODE_W-1:0]     mode,
    input  logic [SEL_W-1:0]      sel,
    input  logic [DW-1:0]         disp,
    input  logic [AW-1:0]         dir_addr,
    output logic [AW-1:0]         eff_addr,
    output logic                  illegal,
    output logic                  upd_en,
    output logic [AW-1:0]         upd_val
);
    typedef struct packed {
        logic [AW-1:0] ea;
        logic          bad;
        logic          upd;
        logic [AW-1:0] nval;
    } ea_res_t;

    ea_res_t       res_d;
    logic [AW-1:0] base;
    logic          sel_bad;

    always_comb begin
        base    = '0;
        sel_bad = 1'b1;
        for (int i = 0; i < NP; i++) begin
            if (sel == SEL_W'(i)) begin
                base    = ptrs[i];
                sel_bad = 1'b0;
            end
        end
    end

    always_comb begin
        res_d = '0;
        unique case (am_mode_e'(mode))
            AM_DIRECT: res_d.ea = dir_addr;
            AM_IND: begin
                res_d.bad = sel_bad;
                res_d.ea  = base;
            end
            AM_DISP: begin
                res_d.bad = sel_bad || (ptr_sel_e'(sel) == PS_X);
                res_d.ea  = base + AW'(disp);
            end
            AM_PREDEC: begin
                res_d.bad  = sel_bad;
                res_d.ea   = base - AW'(1);
                res_d.upd  = 1'b1;
                res_d.nval = base - AW'(1);
            end
            AM_POSTINC: begin
                res_d.bad  = sel_bad;
                res_d.ea   = base;
                res_d.upd  = 1'b1;
                res_d.nval = base + AW'(1);
            end
            default: res_d.bad = 1'b1;
        endcase
        if (res_d.bad) begin
            res_d.ea  = '0;
            res_d.upd = 1'b0;
        end
    end

    assign eff_addr = res_d.ea;
    assign illegal  = res_d.bad;
    assign upd_en   = req_valid && res_d.upd;
    assign upd_val  = res_d.nval;
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import ptr_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NP = PTR_NUM
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_en,
    input  logic [SEL_W-1:0]      upd_sel,
    input  logic [AW-1:0]         upd_val,
    input  logic [NP-1:0]         ld_en,
    input  logic [NP*AW-1:0]      ld_data,
    output logic [NP-1:0][AW-1:0] ptrs
);
    typedef struct packed {
        logic [NP-1:0][AW-1:0] p;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NP; i++) begin
            if (ld_en[i]) begin
                st_d.p[i] = ld_data[AW*i +: AW];
            end else if (upd_en && upd_sel == SEL_W'(i)) begin
                st_d.p[i] = upd_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptrs = st_q.p;
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
    import ptr_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DISP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [MODE_W-1:0]      mode,
    input  logic [SEL_W-1:0]       ptr_sel,
    input  logic [DW-1:0]          disp,
    input  logic [AW-1:0]          dir_addr,
    input  logic [PTR_NUM-1:0]     ptr_ld_en,
    input  logic [PTR_NUM*AW-1:0]  ptr_ld_data,
    output logic [AW-1:0]          eff_addr,
    output logic                   illegal,
    output logic [AW-1:0]          ptr_x,
    output logic [AW-1:0]          ptr_y,
    output logic [AW-1:0]          ptr_z
);
    logic [PTR_NUM-1:0][AW-1:0] ptrs;
    logic                       upd_en;
    logic [AW-1:0]              upd_val;

    ptr_ea_gen #(.AW(AW), .DW(DW), .NP(PTR_NUM)) u_ea (
        .ptrs     (ptrs),
        .req_valid(req_valid),
        .mode     (mode),
        .sel      (ptr_sel),
        .disp     (disp),
        .dir_addr (dir_addr),
        .eff_addr (eff_addr),
        .illegal  (illegal),
        .upd_en   (upd_en),
        .upd_val  (upd_val)
    );

    ptr_regfile #(.AW(AW), .NP(PTR_NUM)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (upd_en),
        .upd_sel(ptr_sel),
        .upd_val(upd_val),
        .ld_en  (ptr_ld_en),
        .ld_data(ptr_ld_data),
        .ptrs   (ptrs)
    );

    assign ptr_x = ptrs[0];
    assign ptr_y = ptrs[1];
    assign ptr_z = ptrs[2];
endmodule

// File: rtl/ptr_addr_unit_chk.sv
module ptr_addr_unit_chk
    import ptr_addr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [MODE_W-1:0]     mode,
    input logic [SEL_W-1:0]      ptr_sel,
    input logic [AW-1:0]         dir_addr,
    input logic [PTR_NUM-1:0]    ptr_ld_en,
    input logic [PTR_NUM*AW-1:0] ptr_ld_data,
    input logic [AW-1:0]         eff_addr,
    input logic                  illegal,
    input logic [AW-1:0]         ptr_x,
    input logic [AW-1:0]         ptr_y,
    input logic [AW-1:0]         ptr_z
);
    assert_ptr_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (ptr_x == '0 && ptr_y == '0 && ptr_z == '0));

    assert_direct_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_DIRECT) |-> (eff_addr == dir_addr && !illegal));

    assert_postinc_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_POSTINC && ptr_sel == PS_X && !ptr_ld_en[0])
        |=> ptr_x == $past(ptr_x) + AW'(1));

    assert_predec_z_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_PREDEC && ptr_sel == PS_Z && !ptr_ld_en[2])
        |=> ptr_z == $past(ptr_z) - AW'(1));

    assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && ptr_ld_en == '0)
        |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && ptr_ld_en == '0)
        |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld_en[1] |=> ptr_y == $past(ptr_ld_data[AW +: AW]));

    assert_disp_x_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_DISP && ptr_sel == PS_X) |-> (illegal && eff_addr == '0));
endmodule

bind ptr_addr_unit ptr_addr_unit_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .mode       (mode),
    .ptr_sel    (ptr_sel),
    .dir_addr   (dir_addr),
    .ptr_ld_en  (ptr_ld_en),
    .ptr_ld_data(ptr_ld_data),
    .eff_addr   (eff_addr),
    .illegal    (illegal),
    .ptr_x      (ptr_x),
    .ptr_y      (ptr_y),
    .ptr_z      (ptr_z)
);

// File: tb/ptr_addr_unit_bench.sv
module ptr_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic [5:0]  disp = '0;
    logic [15:0] dir_addr = '0;
    logic [2:0]  ptr_ld_en = '0;
    logic [47:0] ptr_ld_data = '0;
    logic [15:0] eff_addr, ptr_x, ptr_y, ptr_z;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ptr_addr_unit u_ptr_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .ptr_sel(ptr_sel), .disp(disp), .dir_addr(dir_addr),
        .ptr_ld_en(ptr_ld_en), .ptr_ld_data(ptr_ld_data),
        .eff_addr(eff_addr), .illegal(illegal),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic [1:0]  sel;
        logic [5:0]  dsp;
        logic [15:0] dir;
        logic [15:0] pre;
        logic [15:0] ea;
        logic        ill;
        logic [15:0] post;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 6'd0,  16'h1234, 16'h0050, 16'h1234, 1'b0, 16'h0050}, // R2
        '{3'd1, 2'd1, 6'd0,  16'h0000, 16'h0460, 16'h0460, 1'b0, 16'h0460}, // R3
        '{3'd2, 2'd1, 6'd63, 16'h0000, 16'h0100, 16'h013F, 1'b0, 16'h0100}, // R4
        '{3'd2, 2'd2, 6'd5,  16'h0000, 16'hFFFE, 16'h0003, 1'b0, 16'hFFFE}, // R4 wrap
        '{3'd2, 2'd0, 6'd7,  16'h0000, 16'h0200, 16'h0000, 1'b1, 16'h0200}, // R5
        '{3'd3, 2'd2, 6'd0,  16'h0000, 16'h0060, 16'h005F, 1'b0, 16'h005F}, // R6
        '{3'd4, 2'd0, 6'd0,  16'h0000, 16'h045F, 16'h045F, 1'b0, 16'h0460}, // R7
        '{3'd3, 2'd0, 6'd0,  16'h0000, 16'h0000, 16'hFFFF, 1'b0, 16'hFFFF}, // R8
        '{3'd4, 2'd1, 6'd0,  16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0000}, // R8
        '{3'd4, 2'd3, 6'd0,  16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h0000}, // R11
        '{3'd5, 2'd1, 6'd0,  16'h0000, 16'h0010, 16'h0000, 1'b1, 16'h0010}  // R11
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sel_ptr(input logic [1:0] s);
        case (s)
            2'd0: return ptr_x;
            2'd1: return ptr_y;
            default: return ptr_z;
        endcase
    endfunction

    task automatic load_ptr(input int idx, input logic [15:0] val);
        @(negedge clk);
        ptr_ld_en = '0;
        ptr_ld_en[idx] = 1'b1;
        ptr_ld_data[16*idx +: 16] = val;
        @(negedge clk);
        ptr_ld_en = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 x", ptr_x, 16'h0);
        chk("R1 y", ptr_y, 16'h0);
        chk("R1 z", ptr_z, 16'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].sel != 2'd3) load_ptr(int'(VECS[v].sel), VECS[v].pre);
            @(negedge clk);
            mode = VECS[v].md; ptr_sel = VECS[v].sel;
            disp = VECS[v].dsp; dir_addr = VECS[v].dir;
            req_valid = 1'b1;
            #1;
            chk($sformatf("vec%0d ea R2-7", v), eff_addr, VECS[v].ea);
            chk($sformatf("vec%0d illegal R5/R11", v), 16'(illegal), 16'(VECS[v].ill));
            @(negedge clk);
            req_valid = 1'b0;
            if (VECS[v].sel != 2'd3)
                chk($sformatf("vec%0d ptr R6/R7/R8", v), sel_ptr(VECS[v].sel), VECS[v].post);
        end

        // R10: no update without req_valid
        load_ptr(1, 16'h0300);
        @(negedge clk);
        mode = 3'd4; ptr_sel = 2'd1; req_valid = 1'b0;
        @(negedge clk);
        chk("R10 y held", ptr_y, 16'h0300);

        // R9: load beats auto-update of the same pointer
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd4; ptr_sel = 2'd1;
        ptr_ld_en = 3'b010; ptr_ld_data[31:16] = 16'hABCD;
        @(negedge clk);
        req_valid = 1'b0; ptr_ld_en = '0;
        chk("R9 load wins", ptr_y, 16'hABCD);

        // R9: load of another pointer alongside update
        load_ptr(2, 16'h0400);
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd3; ptr_sel = 2'd2;
        ptr_ld_en = 3'b001; ptr_ld_data[15:0] = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0; ptr_ld_en = '0;
        chk("R9 other load x", ptr_x, 16'h7777);
        chk("R9 update z", ptr_z, 16'h03FF);

        // R12: update touches only selected pointer
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd4; ptr_sel = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 z inc", ptr_z, 16'h0400);
        chk("R12 x held", ptr_x, 16'h7777);
        chk("R12 y held", ptr_y, 16'hABCD);

        // R1: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async x", ptr_x, 16'h0);
        chk("R1 async y", ptr_y, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule